// File: doc/BRIEF.md
# Partitioned Frame Buffer Admission

This block keeps the books for a pool of frame data buffer slots and decides, cycle by cycle, whether a slot may be taken. The pool is split into a temporary region for frames that have not yet been classified, six reserved regions for the upper classes (2 to 7), one reserved region per source port, and one shared pool. Every region size is a configuration input. The buffer memory and the free-address list are outside the block.

A frame that arrives asks for a temporary slot. Once the forwarding logic knows the frame's class and source port, a classify request moves the frame out of the temporary region. The frame is charged to its class reservation if there is room. If not, it goes to its port reservation. If that is also full, it goes to the shared pool. When none of these has room, the frame is dropped. The block returns a region code on every grant. The caller stores that code with the frame and presents it again when the frame leaves, so that the matching counter is decremented. Because a misbehaving port or class fills its own reservation first, it cannot take the slots that other ports and classes rely on.

Grants and drops are combinational outputs in the cycle of the request. Counters change at the next rising clock edge.

Top module: `fdb_admit`

## Requirements
- R1: An allocate request is granted in the same cycle when the temporary count, after any release by a classify in the same cycle, is below `cfg_temp_size`. The temporary count then rises by one at the next edge.
- R2: An allocate request is refused when the temporary region is full. A refused allocate leaves `temp_cnt` unchanged.
- R3: Classes 0 and 1 have no class reservation. A classify for class 0 or 1 is never charged to region code 0 (class). It falls through to its port reservation or to the shared pool.
- R4: A classify is granted to the first region with room, in the order class (code 0), source port (code 1), shared (code 2). `cls_region` gives that code, and the chosen counter rises by one.
- R5: When no region has room, a classify raises `cls_drop` with `cls_region` = 3. The temporary slot is released in both the grant case and the drop case. `cls_gnt` and `cls_drop` are never high together.
- R6: A classify presented while `temp_cnt` is 0 is ignored. It raises no grant and no drop, and `cls_region` is 3.
- R7: A free request decrements the counter selected by `free_region`:
  - code 0: the class counter of `free_cls`;
  - code 1: the port counter of `free_port`;
  - code 2: the shared counter.

  A code-0 free for class 0 or 1 changes nothing.
- R8: A free aimed at a counter that is already 0 leaves it at 0 (no underflow).
- R9: Requests in one cycle take effect in the order free, classify, allocate. A slot freed in a cycle can be taken by a classify in the same cycle. A temporary slot released by a classify can be taken by an allocate in the same cycle.
- R10: Reset (`rst_n` low) clears every counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_temp_size | input | CW | Temporary region size |
| cfg_cls_size | input | (NCLS-NUNRES)*CW | Reservation per class 2..7, class c at slice c-2 |
| cfg_port_size | input | NPORT*CW | Reservation per source port |
| cfg_shared_size | input | CW | Shared pool size |
| alloc_req | input | 1 | Request a temporary slot |
| alloc_gnt | output | 1 | Temporary slot granted |
| cls_req | input | 1 | Classify one temporary frame |
| cls_class | input | CLW | Class of the frame being classified |
| cls_port | input | PW | Source port of the frame being classified |
| cls_gnt | output | 1 | Frame admitted |
| cls_drop | output | 1 | Frame refused, temporary slot released |
| cls_region | output | 2 | Region charged: 0 class, 1 port, 2 shared, 3 none |
| free_req | input | 1 | Release one admitted frame |
| free_region | input | 2 | Region code stored at admission |
| free_cls | input | CLW | Class of the frame being freed |
| free_port | input | PW | Source port of the frame being freed |
| temp_cnt | output | CW | Temporary slots in use |
| cls_cnt | output | (NCLS-NUNRES)*CW | Class reservation usage, class c at slice c-2 |
| port_cnt | output | NPORT*CW | Port reservation usage |
| shared_cnt | output | CW | Shared pool usage |

## Verification
The bench goes after the cascade and the ordering corners, each of which a faulty design would get visibly wrong:
- Frames of one class and port are classified until the class, port and shared regions are each exhausted. A wrong priority shows up as the wrong region code, or as a drop while room remains.
- A classify and an allocate are issued together against a full temporary region. A design that allocates before it releases refuses the allocate.
- A free of the shared pool comes in the same cycle as a classify that needs it. A design that frees last drops the frame.
- A low class is used to show that a design which reserves slots for classes 0 and 1 would charge the class region.
- Repeated frees at zero and a classify with no temporary frame expose counters that wrap or that release phantom slots.

// File: rtl/fdb_pkg.sv
package fdb_pkg;
    typedef enum logic [1:0] {
        RG_CLASS  = 2'd0,
        RG_PORT   = 2'd1,
        RG_SHARED = 2'd2,
        RG_NONE   = 2'd3
    } region_e;
endpackage

// File: rtl/fdb_slot_ctr.sv
// One occupancy counter: release first, then take; never wraps below zero.
module fdb_slot_ctr #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] q,
    output logic          room
);
    logic          dec_ok;
    logic [CW-1:0] q_rel;

    always_comb begin
        dec_ok = dec && (q != '0);
        q_rel  = q - CW'(dec_ok);
        room   = (q_rel < limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_rel + CW'(inc);
    end

    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && q == '0) |=> (q == '0));

    // R1
    take_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |=> (q == $past(q) + CW'(1)));
endmodule

// File: rtl/fdb_route.sv
// Charge-order selection for a classified frame.
module fdb_route
    import fdb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req,
    input  logic    has_temp,
    input  logic    room_cls,
    input  logic    room_port,
    input  logic    room_sh,
    output logic    gnt,
    output logic    drop,
    output region_e region
);
    always_comb begin
        gnt    = 1'b0;
        drop   = 1'b0;
        region = RG_NONE;
        if (req && has_temp) begin
            if (room_cls) begin
                gnt = 1'b1; region = RG_CLASS;
            end else if (room_port) begin
                gnt = 1'b1; region = RG_PORT;
            end else if (room_sh) begin
                gnt = 1'b1; region = RG_SHARED;
            end else begin
                drop = 1'b1;
            end
        end
    end

    // R5
    gnt_drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gnt, drop}));

    // R6
    no_temp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !has_temp) |-> (!gnt && !drop));
endmodule

// File: rtl/fdb_admit.sv
module fdb_admit
    import fdb_pkg::*;
#(
    parameter int CW     = 8,
    parameter int NCLS   = 8,
    parameter int NUNRES = 2,
    parameter int NPORT  = 8,
    parameter int CLW    = $clog2(NCLS),
    parameter int PW     = $clog2(NPORT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [CW-1:0]               cfg_temp_size,
    input  logic [(NCLS-NUNRES)*CW-1:0] cfg_cls_size,
    input  logic [NPORT*CW-1:0]         cfg_port_size,
    input  logic [CW-1:0]               cfg_shared_size,
    input  logic                        alloc_req,
    output logic                        alloc_gnt,
    input  logic                        cls_req,
    input  logic [CLW-1:0]              cls_class,
    input  logic [PW-1:0]               cls_port,
    output logic                        cls_gnt,
    output logic                        cls_drop,
    output logic [1:0]                  cls_region,
    input  logic                        free_req,
    input  logic [1:0]                  free_region,
    input  logic [CLW-1:0]              free_cls,
    input  logic [PW-1:0]               free_port,
    output logic [CW-1:0]               temp_cnt,
    output logic [(NCLS-NUNRES)*CW-1:0] cls_cnt,
    output logic [NPORT*CW-1:0]         port_cnt,
    output logic [CW-1:0]               shared_cnt
);
    localparam int NRES = NCLS - NUNRES;

    region_e          route_rg;
    logic             has_temp, temp_room;
    logic [NRES-1:0]  c_room;
    logic [NPORT-1:0] p_room;
    logic             sh_room;
    logic             room_cls, room_port;

    assign has_temp   = (temp_cnt != '0);
    assign cls_region = route_rg;

    // Temporary region: released by any classify with a frame waiting,
    // taken by an allocate that sees room after that release.
    fdb_slot_ctr #(.CW(CW)) u_temp (
        .clk(clk), .rst_n(rst_n),
        .inc(alloc_gnt), .dec(cls_req && has_temp),
        .limit(cfg_temp_size), .q(temp_cnt), .room(temp_room)
    );
    assign alloc_gnt = alloc_req && temp_room;

    for (genvar c = 0; c < NRES; c++) begin : g_cls
        fdb_slot_ctr #(.CW(CW)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .inc(cls_gnt && route_rg == RG_CLASS &&
                 cls_class == CLW'(c + NUNRES)),
            .dec(free_req && free_region == RG_CLASS &&
                 free_cls == CLW'(c + NUNRES)),
            .limit(cfg_cls_size[c*CW +: CW]),
            .q(cls_cnt[c*CW +: CW]), .room(c_room[c])
        );
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fdb_slot_ctr #(.CW(CW)) u_ctr (
            .clk(clk), .rst_n(rst_n),
            .inc(cls_gnt && route_rg == RG_PORT && cls_port == PW'(p)),
            .dec(free_req && free_region == RG_PORT && free_port == PW'(p)),
            .limit(cfg_port_size[p*CW +: CW]),
            .q(port_cnt[p*CW +: CW]), .room(p_room[p])
        );
    end

    fdb_slot_ctr #(.CW(CW)) u_shared (
        .clk(clk), .rst_n(rst_n),
        .inc(cls_gnt && route_rg == RG_SHARED),
        .dec(free_req && free_region == RG_SHARED),
        .limit(cfg_shared_size), .q(shared_cnt), .room(sh_room)
    );

    always_comb begin
        room_cls  = 1'b0;
        room_port = 1'b0;
        for (int c = 0; c < NRES; c++)
            if (cls_class == CLW'(c + NUNRES)) room_cls = c_room[c];
        for (int p = 0; p < NPORT; p++)
            if (cls_port == PW'(p)) room_port = p_room[p];
    end

    fdb_route u_route (
        .clk(clk), .rst_n(rst_n),
        .req(cls_req), .has_temp(has_temp),
        .room_cls(room_cls), .room_port(room_port), .room_sh(sh_room),
        .gnt(cls_gnt), .drop(cls_drop), .region(route_rg)
    );

    // R3
    low_class_unreserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_gnt && cls_region == RG_CLASS) |-> (cls_class >= CLW'(NUNRES)));

    // R2
    refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_gnt && !cls_req) |=> $stable(temp_cnt));
endmodule

// File: tb/fdb_admit_tb.sv
module fdb_admit_tb;
    localparam int CW = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  cfg_temp_size, cfg_shared_size;
    logic [47:0] cfg_cls_size;
    logic [63:0] cfg_port_size;
    logic        alloc_req, alloc_gnt, cls_req, cls_gnt, cls_drop, free_req;
    logic [2:0]  cls_class, cls_port, free_cls, free_port;
    logic [1:0]  cls_region, free_region;
    logic [7:0]  temp_cnt, shared_cnt;
    logic [47:0] cls_cnt;
    logic [63:0] port_cnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fdb_admit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_temp_size(cfg_temp_size), .cfg_cls_size(cfg_cls_size),
        .cfg_port_size(cfg_port_size), .cfg_shared_size(cfg_shared_size),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt),
        .cls_req(cls_req), .cls_class(cls_class), .cls_port(cls_port),
        .cls_gnt(cls_gnt), .cls_drop(cls_drop), .cls_region(cls_region),
        .free_req(free_req), .free_region(free_region),
        .free_cls(free_cls), .free_port(free_port),
        .temp_cnt(temp_cnt), .cls_cnt(cls_cnt),
        .port_cnt(port_cnt), .shared_cnt(shared_cnt)
    );

    typedef struct packed {
        logic       alc;
        logic       cls;
        logic [2:0] ccl;
        logic [2:0] cpt;
        logic       fre;
        logic [1:0] frg;
        logic [2:0] fcl;
        logic [2:0] fpt;
        logic       eag;
        logic       ecg;
        logic       ecd;
        logic [1:0] erg;
        logic [7:0] etmp;
        logic [7:0] esh;
    } vec_t;

    // Sizes: temp 2, every class 1, every port 1, shared 1.
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1,0,0,0,0,0,0,0, 1,0,0,3, 1,0},  // R1 first temp slot
        '{1,0,0,0,0,0,0,0, 1,0,0,3, 2,0},  // R1 second temp slot
        '{1,0,0,0,0,0,0,0, 0,0,0,3, 2,0},  // R2 temp full
        '{0,1,5,0,0,0,0,0, 0,1,0,0, 1,0},  // R4 class region
        '{0,1,5,0,0,0,0,0, 0,1,0,1, 0,0},  // R4 class full -> port
        '{1,1,5,0,0,0,0,0, 1,0,0,3, 1,0},  // R6 classify with no temp frame
        '{1,0,0,0,0,0,0,0, 1,0,0,3, 2,0},  // R1
        '{0,1,5,0,0,0,0,0, 0,1,0,2, 1,1},  // R4 class+port full -> shared
        '{1,1,1,0,0,0,0,0, 1,0,1,3, 1,1},  // R5 drop, R3 class 1 unreserved
        '{1,0,0,0,0,0,0,0, 1,0,0,3, 2,1},  // R1
        '{1,1,1,1,0,0,0,0, 1,1,0,1, 2,1},  // R9 release then allocate, R3
        '{0,1,0,0,1,2,0,0, 0,1,0,2, 1,1},  // R9 free shared then classify
        '{0,0,0,0,1,0,5,0, 0,0,0,3, 1,1},  // R7 free class 5
        '{0,0,0,0,1,2,0,0, 0,0,0,3, 1,0},  // R7 free shared
        '{0,0,0,0,1,2,0,0, 0,0,0,3, 1,0},  // R8 free shared at zero
        '{0,1,5,2,0,0,0,0, 0,1,0,0, 0,0},  // R7 class 5 reusable
        '{0,1,3,3,0,0,0,0, 0,0,0,3, 0,0},  // R6 no temp frame
        '{0,0,0,0,1,0,1,0, 0,0,0,3, 0,0},  // R7 class-1 free ignored
        '{0,0,0,0,1,1,0,0, 0,0,0,3, 0,0}   // R7 free port 0
    };

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        alloc_req = 0; cls_req = 0; free_req = 0;
        cls_class = 0; cls_port = 0; free_region = 0; free_cls = 0; free_port = 0;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cfg_temp_size = 8'd2; cfg_shared_size = 8'd1;
        cfg_cls_size = {6{8'd1}}; cfg_port_size = {8{8'd1}};
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R10 reset state
        check("R10 temp_cnt", temp_cnt, 0);
        check("R10 shared_cnt", shared_cnt, 0);
        check("R10 cls_cnt", (cls_cnt == '0) ? 1 : 0, 1);
        check("R10 port_cnt", (port_cnt == '0) ? 1 : 0, 1);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            alloc_req = VEC[i].alc; cls_req = VEC[i].cls;
            cls_class = VEC[i].ccl; cls_port = VEC[i].cpt;
            free_req = VEC[i].fre; free_region = VEC[i].frg;
            free_cls = VEC[i].fcl; free_port = VEC[i].fpt;
            #1;
            check($sformatf("R1/R2 alloc_gnt v%0d", i), alloc_gnt, VEC[i].eag);
            check($sformatf("R4 cls_gnt v%0d", i), cls_gnt, VEC[i].ecg);
            check($sformatf("R5 cls_drop v%0d", i), cls_drop, VEC[i].ecd);
            check($sformatf("R4 cls_region v%0d", i), cls_region, VEC[i].erg);
            @(posedge clk); #1;
            check($sformatf("R9 temp_cnt v%0d", i), temp_cnt, VEC[i].etmp);
            check($sformatf("R7 shared_cnt v%0d", i), shared_cnt, VEC[i].esh);
        end
        @(negedge clk); idle();

        // Directed: per-region counters after the table
        check("R7 class5 cnt", cls_cnt[3*CW +: CW], 1);
        check("R7 class3 cnt", cls_cnt[1*CW +: CW], 0);
        check("R7 port0 cnt", port_cnt[0*CW +: CW], 0);
        check("R3 port1 cnt", port_cnt[1*CW +: CW], 1);
        check("R4 port2 cnt", port_cnt[2*CW +: CW], 0);

        // R8 free port at zero twice
        free_req = 1; free_region = 2'd1; free_port = 3'd0;
        @(posedge clk); @(posedge clk); #1;
        check("R8 port0 stays zero", port_cnt[0*CW +: CW], 0);
        @(negedge clk); idle();

        // R10 reset in mid-run
        alloc_req = 1;
        @(posedge clk); #1;
        check("R1 temp before reset", temp_cnt, 1);
        @(negedge clk); idle(); rst_n = 0;
        @(posedge clk); #1;
        check("R10 temp after reset", temp_cnt, 0);
        check("R10 cls_cnt after reset", (cls_cnt == '0) ? 1 : 0, 1);
        check("R10 port_cnt after reset", (port_cnt == '0) ? 1 : 0, 1);
        @(negedge clk); rst_n = 1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule